// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns two encoder inputs, A and B, into a 32-bit position count. A two-bit source field picks how the inputs are read. In quadrature mode every edge of either input is counted and the phase order sets the direction. In pulse-and-direction mode the rising edges of A are counted and the level of B sets the direction. In the up-count and down-count modes only A is counted, on its rising edges or on both of its edges, and B is ignored.

The count stays between zero and a programmable ceiling and wraps at either end. Overflow, underflow and direction changes set sticky flags. Software clears a flag by writing a one to it. Each flag can be enabled onto a single interrupt line. Software reaches the count, the ceiling, the configuration, the flags and the direction status through a small synchronous register port: a write strobe, a 3-bit address, write data and a combinational read-data bus.

Top module: `qep_position_counter`

## Requirements
- R1: After reset the count is 0, the ceiling is all ones, counting is disabled, the source mode is quadrature, the flag register reads 0, `irq` is low and status bit 5 reads 1 (forward).
- R2: In source mode 0 (decoder control bits 15:14), each edge of A or B moves the count by one. The order A-leads-B, with (A,B) going 00,10,11,01,00, counts up. The order B-leads-A counts down.
- R3: In source mode 0, a clock in which both synchronized inputs change leaves the count unchanged.
- R4: In source mode 1, each rising edge of A counts once and falling edges of A do not count. B high means up and B low means down. A change of B alone does not count.
- R5: In source mode 2 the count goes up and in mode 3 it goes down, on A only. Changes of B have no effect. When decoder control bit 11 is 0 only rising edges of A count. When it is 1, both edges of A count.
- R6: Control register bit 3 enables counting. While it is 0, input edges leave the count unchanged.
- R7: Counting up from a count at or above the ceiling loads 0 and sets the overflow flag at flag bit 6.
- R8: Counting down from 0 loads the ceiling and sets the underflow flag at flag bit 5.
- R9: Status bit 5 shows the direction of the last counted event (1 is up). A counted event whose direction differs from the previous one sets the direction-change flag at flag bit 3.
- R10: Writing the clear register (address 6) clears each flag whose bit is 1 in the written data. Bits written as 0 leave their flags unchanged.
- R11: The interrupt-enable register (address 4) uses the same bit positions as the flags. Flag bit 0 and the `irq` output are high exactly when some flag is set and its enable bit is set.
- R12: A write to the count register (address 0) wins over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 count, 1 ceiling, 2 decoder control, 3 control, 4 interrupt enable, 5 flags, 6 clear, 7 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The stored direction bit is the state most likely to go wrong without being seen. If it is wrong, the next counted event raises a direction-change flag it should not, or misses one. That shows in the flag register, and on `irq` when enabled, one cycle after the event. A wrong count or a wrong wrap value is visible on the count register three clocks after the input edge, made up of two synchronizer stages and one count register. The bench reads the count after every group of edges, so a single missing or extra step is caught before the next group. The same-cycle write case is timed to land in the exact cycle of the count event.

// File: rtl/qep_pkg.sv
package qep_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_PDIR = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_mode_e;

  localparam int ADDR_W    = 3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CEIL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLG   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_STS   = 3'd7;

  localparam int DEC_MODE_LSB = 14;
  localparam int DEC_BOTH     = 11;
  localparam int CTL_EN       = 3;
  localparam int FB_INT       = 0;
  localparam int FB_DIRCHG    = 3;
  localparam int FB_UNDER     = 5;
  localparam int FB_OVER      = 6;
  localparam int STS_DIR      = 5;

  // internal flag vector order
  localparam int NFLAG  = 3;
  localparam int FI_DC  = 0;
  localparam int FI_UNF = 1;
  localparam int FI_OVF = 2;
endpackage

// File: rtl/qep_sync.sv
module qep_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;
      always_comb sh_d = {sh_q[STAGES-2:0], din[g]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
      assign dout[g] = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qep_decoder.sv
module qep_decoder
  import qep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a_s,
  input  logic      b_s,
  input  src_mode_e mode,
  input  logic      both_edges,
  output logic      step,
  output logic      up
);
  logic a_q, b_q;
  logic a_chg, b_chg, a_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
    end
  end

  always_comb begin
    a_chg  = a_s ^ a_q;
    b_chg  = b_s ^ b_q;
    a_rise = a_s & ~a_q;
    step   = 1'b0;
    up     = 1'b1;
    unique case (mode)
      SRC_QUAD: begin
        step = a_chg ^ b_chg;
        up   = a_chg ? (a_s ^ b_s) : ~(a_s ^ b_s);
      end
      SRC_PDIR: begin
        step = a_rise;
        up   = b_s;
      end
      SRC_UP: begin
        step = both_edges ? a_chg : a_rise;
        up   = 1'b1;
      end
      SRC_DOWN: begin
        step = both_edges ? a_chg : a_rise;
        up   = 1'b0;
      end
      default: ;
    endcase
  end

  AST_INVALID_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_QUAD && a_chg && b_chg) |-> !step); // R3
  AST_B_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == SRC_UP || mode == SRC_DOWN) && !a_chg) |-> !step); // R5
endmodule

// File: rtl/qep_counter.sv
module qep_counter
  import qep_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             up,
  input  logic [CNT_W-1:0] ceil,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [NFLAG-1:0] clr,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic [NFLAG-1:0] flags
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic [NFLAG-1:0] flg_q, flg_d, set;
  logic             cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    set   = '0;
    if (cnt_wr) begin
      cnt_d = cnt_wval;
    end else if (en && step) begin
      dir_d = up;
      set[FI_DC] = (up != dir_q);
      if (up) begin
        if (cnt_q >= ceil) begin
          cnt_d = '0;
          set[FI_OVF] = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ceil;
          set[FI_UNF] = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    flg_d  = (flg_q & ~clr) | set;
    cnt_ce = cnt_wr | (en & step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      flg_q <= '0;
    end else begin
      if (cnt_ce) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
      end
      flg_q <= flg_d;
    end
  end

  assign count = cnt_q;
  assign dir   = dir_q;
  assign flags = flg_q;

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(cnt_q)); // R6
  AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[FI_OVF]) |-> (cnt_q == '0)); // R7
  AST_UNF_TO_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[FI_UNF]) |-> (cnt_q == $past(ceil))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cnt_wval))); // R12
endmodule

// File: rtl/qep_position_counter.sv
module qep_position_counter
  import qep_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]       ab_s;
  logic             step, up, dir;
  logic [CNT_W-1:0] count;
  logic [NFLAG-1:0] flags, clr, ien_vec;

  logic [CNT_W-1:0] ceil_q, ceil_d;
  src_mode_e        mode_q, mode_d;
  logic             both_q, both_d;
  logic             en_q, en_d;
  logic [NFLAG-1:0] ien_q, ien_d;
  logic             int_any;

  qep_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_b, enc_a}), .dout(ab_s)
  );

  qep_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .a_s(ab_s[0]), .b_s(ab_s[1]),
    .mode(mode_q), .both_edges(both_q), .step(step), .up(up)
  );

  always_comb begin
    clr = '0;
    if (reg_wr && reg_addr == A_CLR) begin
      clr[FI_DC]  = reg_wdata[FB_DIRCHG];
      clr[FI_UNF] = reg_wdata[FB_UNDER];
      clr[FI_OVF] = reg_wdata[FB_OVER];
    end
  end

  qep_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .step(step), .up(up),
    .ceil(ceil_q), .cnt_wr(reg_wr && reg_addr == A_COUNT),
    .cnt_wval(reg_wdata), .clr(clr),
    .count(count), .dir(dir), .flags(flags)
  );

  // configuration registers: next state
  always_comb begin
    ceil_d = ceil_q;
    mode_d = mode_q;
    both_d = both_q;
    en_d   = en_q;
    ien_d  = ien_q;
    if (reg_wr) begin
      unique case (reg_addr)
        A_CEIL: ceil_d = reg_wdata;
        A_DEC: begin
          mode_d = src_mode_e'(reg_wdata[DEC_MODE_LSB +: 2]);
          both_d = reg_wdata[DEC_BOTH];
        end
        A_CTL: en_d = reg_wdata[CTL_EN];
        A_IEN: begin
          ien_d[FI_DC]  = reg_wdata[FB_DIRCHG];
          ien_d[FI_UNF] = reg_wdata[FB_UNDER];
          ien_d[FI_OVF] = reg_wdata[FB_OVER];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q <= '1;
      mode_q <= SRC_QUAD;
      both_q <= 1'b0;
      en_q   <= 1'b0;
      ien_q  <= '0;
    end else if (reg_wr) begin
      ceil_q <= ceil_d;
      mode_q <= mode_d;
      both_q <= both_d;
      en_q   <= en_d;
      ien_q  <= ien_d;
    end
  end

  assign ien_vec = ien_q;
  assign int_any = |(flags & ien_vec);
  assign irq     = int_any;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_COUNT: reg_rdata = count;
      A_CEIL:  reg_rdata = ceil_q;
      A_DEC: begin
        reg_rdata[DEC_MODE_LSB +: 2] = mode_q;
        reg_rdata[DEC_BOTH]          = both_q;
      end
      A_CTL:   reg_rdata[CTL_EN] = en_q;
      A_IEN: begin
        reg_rdata[FB_DIRCHG] = ien_q[FI_DC];
        reg_rdata[FB_UNDER]  = ien_q[FI_UNF];
        reg_rdata[FB_OVER]   = ien_q[FI_OVF];
      end
      A_FLG: begin
        reg_rdata[FB_INT]    = int_any;
        reg_rdata[FB_DIRCHG] = flags[FI_DC];
        reg_rdata[FB_UNDER]  = flags[FI_UNF];
        reg_rdata[FB_OVER]   = flags[FI_OVF];
      end
      A_STS:   reg_rdata[STS_DIR] = dir;
      default: ;
    endcase
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R11
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR && reg_wdata[FB_OVER] && !(en_q && step))
      |=> !flags[FI_OVF]); // R10
endmodule

// File: tb/qep_position_counter_tb.sv
module qep_position_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] R_CNT = 3'd0, R_CEIL = 3'd1, R_DEC = 3'd2, R_CTL = 3'd3,
                         R_IEN = 3'd4, R_FLG = 3'd5, R_CLR = 3'd6, R_STS = 3'd7;

  logic clk, rst_n, enc_a, enc_b, reg_wr, irq;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    bit          on_irq;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  qep_position_counter u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = it.on_irq ? {31'd0, irq} : (reg_rdata & it.mask);
      n_chk++;
      if (act !== (it.exp & it.mask)) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e,
                            input logic [31:0] m, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    #1;
    it.exp = e; it.mask = m; it.on_irq = 0; it.tag = tag;
    sbq.push_back(it);
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.exp = {31'd0, e}; it.mask = 32'h1; it.on_irq = 1; it.tag = tag;
    sbq.push_back(it);
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_a();
    ab(1'b1, enc_b);
    ab(1'b0, enc_b);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enc_a = 0; enc_b = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    expect_reg(R_CNT, 32'd0, '1, "R1 count");
    expect_reg(R_CEIL, 32'hFFFF_FFFF, '1, "R1 ceiling");
    expect_reg(R_FLG, 32'd0, '1, "R1 flags");
    expect_reg(R_STS, 32'h20, 32'h20, "R1 status dir");
    expect_reg(R_CTL, 32'd0, '1, "R1 control");
    expect_irq(1'b0, "R1 irq");

    wr(R_CTL, 32'h8);
    ab(1,0); ab(1,1); ab(0,1); ab(0,0);
    expect_reg(R_CNT, 32'd4, '1, "R2 A leads B up");
    expect_reg(R_FLG, 32'd0, 32'h68, "R9 no dirchg while up");
    ab(0,1); ab(1,1); ab(1,0); ab(0,0);
    expect_reg(R_CNT, 32'd0, '1, "R2 B leads A down");
    expect_reg(R_STS, 32'h0, 32'h20, "R9 status down");
    expect_reg(R_FLG, 32'h08, 32'h68, "R9 dirchg flag");

    wr(R_CLR, 32'h0);
    expect_reg(R_FLG, 32'h08, 32'h68, "R10 zero write keeps flag");
    wr(R_CLR, 32'h08);
    expect_reg(R_FLG, 32'h00, 32'h68, "R10 one write clears");

    ab(1,1); ab(0,0);
    expect_reg(R_CNT, 32'd0, '1, "R3 both inputs change");

    wr(R_CEIL, 32'd9);
    ab(0,1);
    expect_reg(R_CNT, 32'd9, '1, "R8 underflow wraps to ceiling");
    expect_reg(R_FLG, 32'h20, 32'h68, "R8 underflow flag");
    expect_irq(1'b0, "R11 irq masked");
    wr(R_IEN, 32'h20);
    expect_irq(1'b1, "R11 irq enabled");
    expect_reg(R_FLG, 32'h21, 32'h69, "R11 global flag bit");
    wr(R_CLR, 32'h68);
    expect_irq(1'b0, "R11 irq after clear");

    ab(0,0);
    expect_reg(R_CNT, 32'd0, '1, "R7 overflow wraps to zero");
    expect_reg(R_FLG, 32'h48, 32'h68, "R7 overflow and R9 dirchg");
    wr(R_CLR, 32'h68);

    wr(R_CTL, 32'h0);
    ab(1,0); ab(1,1); ab(0,1); ab(0,0);
    expect_reg(R_CNT, 32'd0, '1, "R6 disabled holds");
    wr(R_CTL, 32'h8);

    wr(R_DEC, 32'h4000);
    enc_b = 1;
    ab(0,1);
    pulse_a(); pulse_a();
    expect_reg(R_CNT, 32'd2, '1, "R4 rising A with B high");
    ab(0,0);
    pulse_a();
    expect_reg(R_CNT, 32'd1, '1, "R4 B low counts down");

    wr(R_DEC, 32'h8000);
    ab(0,1); ab(0,0); ab(0,1);
    expect_reg(R_CNT, 32'd1, '1, "R5 B ignored in up mode");
    pulse_a(); pulse_a();
    expect_reg(R_CNT, 32'd3, '1, "R5 up rising only");
    wr(R_DEC, 32'h8800);
    pulse_a();
    expect_reg(R_CNT, 32'd5, '1, "R5 up both edges");
    wr(R_DEC, 32'hC000);
    pulse_a();
    ab(0,0);
    expect_reg(R_CNT, 32'd4, '1, "R5 down mode");

    wr(R_DEC, 32'h8000);
    @(negedge clk); enc_a = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = R_CNT; reg_wdata = 32'd7;
    @(negedge clk); reg_wr = 0;
    repeat (5) @(negedge clk);
    expect_reg(R_CNT, 32'd7, '1, "R12 write wins over step");
    ab(0,0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule